// File: doc/BRIEF.md
# Serial Flash Clock and Select Timing Generator

This block turns a fast reference clock into the serial clock and the active-low select lines of a serial flash controller. A configuration input set supplies an enable bit, a clock divisor, a device number with its select mode, and four 8-bit delay counts measured in reference ticks. Each transfer request is framed by a programmed select-to-clock setup gap, a clock-to-deselect hold gap, a minimum deselected gap, and an extra gap whenever the next transfer addresses a different device.

A companion shifter moves the data bits. It learns that clocking has begun from a one-cycle start strobe that coincides with the first rising clock edge. It signals its final bit on a last-edge input, which may pulse at any point during the final clock period. It is told that the select line has been released by a one-cycle done strobe. The serial clock idles low, so the first edge is rising. An idle output reports when the block has nothing in progress.

Top module: `spi_timing_gen`

## Requirements
- R1: The serial clock stays high for exactly div+1 reference ticks and then low for exactly div+1 ticks, where div is the 4-bit divisor. Each transfer starts with a high phase.
- R2: The first rising clock edge comes max(setupDly,1) ticks after the select lines assert. `shiftStart` is high for exactly the one cycle in which that rising edge appears.
- R3: The falling edge that ends the clock period in which `lastEdge` was seen is the final clock edge. The select lines release max(holdDly,1) ticks after it. `xferDone` is high for exactly the first cycle in which the lines are released.
- R4: After a release, the block stays deselected for max(gapDly, 2*(div+1)) ticks, using the divisor of the finished transfer. A request already waiting then asserts the select lines one tick after that window ends.
- R5: When a transfer selects a device number different from the previous transfer, an extra max(switchDly,1) deselected ticks come before the setup gap.
- R6: With the decode bit at 0, the select lines carry an active-low one-hot pattern: line n is low for device n and every other line is high. A device number equal to or above the line count drives no line low.
- R7: With the decode bit at 1, the select lines carry the 4-bit device number unchanged, so that an external decoder can address 16 devices.
- R8: The divisor, the device number and the decode bit are sampled when a request is accepted. Changes to them while a transfer is in progress affect neither the clock timing nor the select lines.
- R9: Outside a transfer, the clock is low and every select line is high. `idle` is high only when the block is in its rest state and no enabled request is waiting, so it stays low through the deselect gap.
- R10: While enable is low, requests are ignored. Clearing enable during a transfer aborts it: in the next cycle the select lines are all high and the clock is low.
- R11: After reset, the select lines are all high, the clock is low, `idle` is high, and both strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgEnable | input | 1 | Block enable; low aborts and blocks transfers |
| cfgDecode | input | 1 | 1: drive the device number; 0: one-hot active-low lines |
| cfgBaudDiv | input | 4 | Clock divisor; the clock period is 2*(div+1) ticks |
| cfgCsSel | input | 4 | Device number |
| cfgSetupDly | input | 8 | Select assert to first clock edge, in ticks |
| cfgHoldDly | input | 8 | Last clock edge to select release, in ticks |
| cfgGapDly | input | 8 | Minimum deselected time between transfers, in ticks |
| cfgSwitchDly | input | 8 | Extra deselected time when the device changes, in ticks |
| xferReq | input | 1 | Transfer request; hold it until `shiftStart` |
| lastEdge | input | 1 | Shifter marks the final clock period |
| sclk | output | 1 | Serial clock, idles low |
| csN | output | 4 | Active-low select lines |
| shiftStart | output | 1 | One-cycle strobe at the first rising clock edge |
| xferDone | output | 1 | One-cycle strobe at select release |
| idle | output | 1 | Nothing in progress and no request waiting |

## Verification
The bench programs zero setup and hold counts. A design that does not clamp them to one tick would raise the clock in the same cycle as the select lines, or drop the select lines on the last clock edge. It queues the next request during the deselect gap, with a gap count smaller than one clock period. A design that skips the one-period floor would reassert the select lines early, and one that ignores the device change would omit the switch gap. Mid-transfer changes to the divisor, device number and decode bit catch a design that reads live configuration: its clock phase lengths or its select pattern would shift partway through. A final abort and a disabled request confirm that the lines release at once and that nothing starts.

// File: rtl/spi_tim_pkg.sv
package spi_tim_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SWITCH,
    ST_SETUP,
    ST_RUN,
    ST_HOLD,
    ST_GAP
  } tState;

  typedef enum logic [1:0] {
    LD_SETUP,
    LD_HOLD,
    LD_GAP,
    LD_SWITCH
  } tLdSel;

  // control -> datapath strobes
  typedef struct packed {
    logic  accept;   // latch divisor / device / mode
    logic  loadCnt;  // load dwell counter
    tLdSel ldSel;    // which delay to load
    logic  runStart; // clock high, half counter reload
    logic  runStep;  // advance half-period counter
    logic  clkOff;   // force clock low
    logic  csOn;     // select lines active
  } tStrobes;

endpackage

// File: rtl/spi_tim_dp.sv
module spi_tim_dp
  import spi_tim_pkg::*;
#(
  parameter int DIV_W = 4,
  parameter int CS_W  = 4,
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  tStrobes          stb,
  input  logic             cfgDecode,
  input  logic [DIV_W-1:0] cfgBaudDiv,
  input  logic [CS_W-1:0]  cfgCsSel,
  input  logic [DLY_W-1:0] cfgSetupDly,
  input  logic [DLY_W-1:0] cfgHoldDly,
  input  logic [DLY_W-1:0] cfgGapDly,
  input  logic [DLY_W-1:0] cfgSwitchDly,
  output logic             dwellDone,
  output logic             halfDone,
  output logic             sclkHigh,
  output logic             switchNeeded,
  output logic             sclk,
  output logic [CS_W-1:0]  csN
);

  localparam int CNT_W = (DLY_W > DIV_W + 2) ? DLY_W : DIV_W + 2;

  logic [DIV_W-1:0] divQ;
  logic [CS_W-1:0]  selQ;
  logic             decQ;
  logic             validQ;
  logic [CNT_W-1:0] dwellCnt;
  logic [CNT_W-1:0] loadVal;
  logic [CNT_W-1:0] periodTicks;
  logic [CNT_W-1:0] gapVal;
  logic [DIV_W:0]   halfTicks;
  logic [DIV_W:0]   halfCnt;
  logic             sclkQ;
  logic [CS_W-1:0]  oneHotN;

  assign halfTicks   = {1'b0, divQ} + (DIV_W + 1)'(1);
  assign periodTicks = CNT_W'({halfTicks, 1'b0});
  assign gapVal      = (CNT_W'(cfgGapDly) > periodTicks) ? CNT_W'(cfgGapDly) : periodTicks;

  always_comb begin
    unique case (stb.ldSel)
      LD_SETUP:  loadVal = CNT_W'(cfgSetupDly);
      LD_HOLD:   loadVal = CNT_W'(cfgHoldDly);
      LD_GAP:    loadVal = gapVal;
      default:   loadVal = CNT_W'(cfgSwitchDly);
    endcase
  end

  // configuration shadow, sampled only when a request is accepted
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divQ   <= '0;
      selQ   <= '0;
      decQ   <= 1'b0;
      validQ <= 1'b0;
    end else if (stb.accept) begin
      divQ   <= cfgBaudDiv;
      selQ   <= cfgCsSel;
      decQ   <= cfgDecode;
      validQ <= 1'b1;
    end
  end

  // dwell counter: a phase lasts max(count,1) ticks
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                             dwellCnt <= '0;
    else if (stb.loadCnt)                  dwellCnt <= loadVal;
    else if (dwellCnt > CNT_W'(1))         dwellCnt <= dwellCnt - CNT_W'(1);
  end

  // serial clock half-period generator
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkQ   <= 1'b0;
      halfCnt <= '0;
    end else if (stb.clkOff) begin
      sclkQ   <= 1'b0;
    end else if (stb.runStart) begin
      sclkQ   <= 1'b1;
      halfCnt <= halfTicks;
    end else if (stb.runStep) begin
      if (halfDone) begin
        sclkQ   <= ~sclkQ;
        halfCnt <= halfTicks;
      end else begin
        halfCnt <= halfCnt - (DIV_W + 1)'(1);
      end
    end
  end

  for (genvar i = 0; i < CS_W; i++) begin : g_line
    assign oneHotN[i] = (selQ != CS_W'(i));
  end

  assign dwellDone    = (dwellCnt <= CNT_W'(1));
  assign halfDone     = (halfCnt <= (DIV_W + 1)'(1));
  assign sclkHigh     = sclkQ;
  assign switchNeeded = validQ && (cfgCsSel != selQ);
  assign sclk         = sclkQ;
  assign csN          = !stb.csOn ? {CS_W{1'b1}} : (decQ ? selQ : oneHotN);

endmodule

// File: rtl/spi_tim_ctrl.sv
module spi_tim_ctrl
  import spi_tim_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    cfgEnable,
  input  logic    xferReq,
  input  logic    lastEdge,
  input  logic    dwellDone,
  input  logic    halfDone,
  input  logic    sclkHigh,
  input  logic    switchNeeded,
  output tStrobes stb,
  output logic    shiftStart,
  output logic    xferDone,
  output logic    idle
);

  tState state;
  tState nxt;
  logic  lastSeen;
  logic  lastNow;

  assign lastNow = lastSeen | lastEdge;

  always_comb begin
    nxt       = state;
    stb       = '0;
    stb.ldSel = LD_SETUP;
    if (!cfgEnable) begin
      nxt        = ST_IDLE;
      stb.clkOff = 1'b1;
    end else begin
      unique case (state)
        ST_IDLE: if (xferReq) begin
          stb.accept  = 1'b1;
          stb.loadCnt = 1'b1;
          if (switchNeeded) begin
            nxt       = ST_SWITCH;
            stb.ldSel = LD_SWITCH;
          end else begin
            nxt = ST_SETUP;
          end
        end
        ST_SWITCH: if (dwellDone) begin
          nxt         = ST_SETUP;
          stb.loadCnt = 1'b1;
        end
        ST_SETUP: if (dwellDone) begin
          nxt          = ST_RUN;
          stb.runStart = 1'b1;
        end
        ST_RUN: begin
          stb.runStep = 1'b1;
          if (halfDone && sclkHigh && lastNow) begin
            nxt         = ST_HOLD;
            stb.loadCnt = 1'b1;
            stb.ldSel   = LD_HOLD;
          end
        end
        ST_HOLD: if (dwellDone) begin
          nxt         = ST_GAP;
          stb.loadCnt = 1'b1;
          stb.ldSel   = LD_GAP;
        end
        default: if (dwellDone) nxt = ST_IDLE;
      endcase
    end
    stb.csOn = (state == ST_SETUP) || (state == ST_RUN) || (state == ST_HOLD);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      lastSeen   <= 1'b0;
      shiftStart <= 1'b0;
      xferDone   <= 1'b0;
    end else begin
      state      <= nxt;
      lastSeen   <= (state == ST_RUN) && (nxt == ST_RUN) && lastNow;
      shiftStart <= (nxt == ST_RUN) && (state != ST_RUN);
      xferDone   <= (state == ST_HOLD) && (nxt == ST_GAP);
    end
  end

  assign idle = (state == ST_IDLE) && !(xferReq && cfgEnable);

endmodule

// File: rtl/spi_timing_gen.sv
module spi_timing_gen
  import spi_tim_pkg::*;
#(
  parameter int DIV_W = 4,
  parameter int CS_W  = 4,
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgEnable,
  input  logic             cfgDecode,
  input  logic [DIV_W-1:0] cfgBaudDiv,
  input  logic [CS_W-1:0]  cfgCsSel,
  input  logic [DLY_W-1:0] cfgSetupDly,
  input  logic [DLY_W-1:0] cfgHoldDly,
  input  logic [DLY_W-1:0] cfgGapDly,
  input  logic [DLY_W-1:0] cfgSwitchDly,
  input  logic             xferReq,
  input  logic             lastEdge,
  output logic             sclk,
  output logic [CS_W-1:0]  csN,
  output logic             shiftStart,
  output logic             xferDone,
  output logic             idle
);

  tStrobes stb;
  logic    dwellDone;
  logic    halfDone;
  logic    sclkHigh;
  logic    switchNeeded;

  spi_tim_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .cfgEnable    (cfgEnable),
    .xferReq      (xferReq),
    .lastEdge     (lastEdge),
    .dwellDone    (dwellDone),
    .halfDone     (halfDone),
    .sclkHigh     (sclkHigh),
    .switchNeeded (switchNeeded),
    .stb          (stb),
    .shiftStart   (shiftStart),
    .xferDone     (xferDone),
    .idle         (idle)
  );

  spi_tim_dp #(
    .DIV_W (DIV_W),
    .CS_W  (CS_W),
    .DLY_W (DLY_W)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .stb          (stb),
    .cfgDecode    (cfgDecode),
    .cfgBaudDiv   (cfgBaudDiv),
    .cfgCsSel     (cfgCsSel),
    .cfgSetupDly  (cfgSetupDly),
    .cfgHoldDly   (cfgHoldDly),
    .cfgGapDly    (cfgGapDly),
    .cfgSwitchDly (cfgSwitchDly),
    .dwellDone    (dwellDone),
    .halfDone     (halfDone),
    .sclkHigh     (sclkHigh),
    .switchNeeded (switchNeeded),
    .sclk         (sclk),
    .csN          (csN)
  );

endmodule

// File: rtl/spi_timing_chk.sv
module spi_timing_chk #(
  parameter int CS_W = 4
) (
  input logic            clk,
  input logic            rstN,
  input logic            cfgEnable,
  input logic            sclk,
  input logic [CS_W-1:0] csN,
  input logic            shiftStart,
  input logic            xferDone,
  input logic            idle
);

  localparam logic [CS_W-1:0] ALL_HIGH = {CS_W{1'b1}};

  AST_START_ON_RISE: assert property (@(posedge clk) disable iff (!rstN)
    shiftStart |-> (sclk && !$past(sclk))); // R2

  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    shiftStart |=> !shiftStart); // R2

  AST_DONE_ON_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    xferDone |-> (csN == ALL_HIGH && $past(csN) != ALL_HIGH)); // R3

  AST_CS_STEADY: assert property (@(posedge clk) disable iff (!rstN)
    (csN != ALL_HIGH && $past(csN) != ALL_HIGH) |-> $stable(csN)); // R8

  AST_CLK_GATED: assert property (@(posedge clk) disable iff (!rstN)
    (csN == ALL_HIGH) |-> !sclk); // R9

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    idle |-> (csN == ALL_HIGH && !sclk && !shiftStart)); // R9

  AST_DISABLE_RELEASES: assert property (@(posedge clk) disable iff (!rstN)
    !cfgEnable |=> (csN == ALL_HIGH && !sclk)); // R10

endmodule

bind spi_timing_gen spi_timing_chk #(.CS_W(CS_W)) u_chk (.*);

// File: tb/tb_spi_timing_gen.sv
`timescale 1ns/1ps
module tb_spi_timing_gen;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cfgEnable = 1'b0;
  logic       cfgDecode = 1'b0;
  logic [3:0] cfgBaudDiv = '0;
  logic [3:0] cfgCsSel = '0;
  logic [7:0] cfgSetupDly = '0;
  logic [7:0] cfgHoldDly = '0;
  logic [7:0] cfgGapDly = '0;
  logic [7:0] cfgSwitchDly = '0;
  logic       xferReq = 1'b0;
  logic       lastEdge = 1'b0;
  logic       sclk;
  logic [3:0] csN;
  logic       shiftStart;
  logic       xferDone;
  logic       idle;

  spi_timing_gen dut (.*);

  always #2.5 clk = ~clk;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  typedef struct {
    logic [3:0] pat;
    int setup, half, hold, per, gap;
    bit dec, chg;
  } tItem;
  tItem q[$];

  // history kept by the driver
  int prevG = 0, prevHalf = 1, prevCs = 0;
  bit haveHist = 0;
  bit monOn = 1;

  function automatic int maxi(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  task automatic runXfer(input bit dec, input int cs, input int dv, input int s,
                         input int h, input int g, input int w, input int per,
                         input bit chg);
    tItem it;
    int nr;
    bit ps;
    it.dec   = dec;
    it.chg   = chg;
    it.pat   = dec ? 4'(cs) : ~(4'b1 << cs);
    it.setup = maxi(s, 1);
    it.half  = dv + 1;
    it.hold  = maxi(h, 1);
    it.per   = per;
    it.gap   = haveHist ? (maxi(prevG, 2 * prevHalf) + 1 + ((cs != prevCs) ? maxi(w, 1) : 0)) : 0;
    q.push_back(it);
    cfgDecode = dec; cfgCsSel = 4'(cs); cfgBaudDiv = 4'(dv);
    cfgSetupDly = 8'(s); cfgHoldDly = 8'(h); cfgGapDly = 8'(g); cfgSwitchDly = 8'(w);
    xferReq = 1'b1;
    do @(negedge clk); while (!shiftStart);
    xferReq = 1'b0;
    if (chg) begin
      cfgBaudDiv = 4'(dv + 5);
      cfgCsSel   = 4'(cs + 1);
      cfgDecode  = !dec;
    end
    nr = 1; ps = 1'b1;
    while (nr < per) begin
      @(negedge clk);
      if (sclk && !ps) nr++;
      ps = sclk;
    end
    lastEdge = 1'b1;
    @(negedge clk);
    lastEdge = 1'b0;
    do @(negedge clk); while (!xferDone);
    chk(!idle, "R9 idle low in gap", idle, 0);
    prevG = g; prevHalf = dv + 1; prevCs = cs; haveHist = 1;
  endtask

  // scoreboard monitor
  tItem cur;
  bit wasCs = 0, wasSclk = 0, stableOk = 1;
  int tCsF = 0, tCsR = 0, tR = 0, tF = 0, rises = 0;

  always @(negedge clk) begin
    if (monOn && rstN) begin
      if (csN != 4'hF && !wasCs) begin
        if (q.size() == 0) begin
          chk(0, "R9 unexpected select", 0, 1);
        end else begin
          cur = q.pop_front();
          chk(csN == cur.pat, cur.dec ? "R7 decoded lines" : "R6 one-hot lines", csN, cur.pat);
          if (cur.gap > 0)
            chk(cyc - tCsR == cur.gap, "R4 R5 deselect time", cyc - tCsR, cur.gap);
        end
        tCsF = cyc; rises = 0; stableOk = 1;
      end
      if (wasCs && csN != 4'hF && csN != cur.pat) stableOk = 0;
      if (sclk && !wasSclk) begin
        rises++;
        if (rises == 1) begin
          chk(cyc - tCsF == cur.setup, "R2 setup gap", cyc - tCsF, cur.setup);
          chk(shiftStart, "R2 start strobe", shiftStart, 1);
        end else begin
          chk(cyc - tF == cur.half, cur.chg ? "R8 low phase" : "R1 low phase", cyc - tF, cur.half);
        end
        tR = cyc;
      end
      if (!sclk && wasSclk) begin
        chk(cyc - tR == cur.half, cur.chg ? "R8 high phase" : "R1 high phase", cyc - tR, cur.half);
        tF = cyc;
      end
      if (csN == 4'hF && wasCs) begin
        chk(cyc - tF == cur.hold, "R3 hold gap", cyc - tF, cur.hold);
        chk(rises == cur.per, "R3 clock periods", rises, cur.per);
        chk(xferDone, "R3 done strobe", xferDone, 1);
        chk(stableOk, "R8 select lines steady", stableOk, 1);
        tCsR = cyc;
      end
      wasCs   = (csN != 4'hF);
      wasSclk = sclk;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    chk(csN == 4'hF, "R11 reset lines", csN, 4'hF);
    chk(sclk == 1'b0, "R11 reset clock", sclk, 0);
    chk(idle == 1'b1, "R11 reset idle", idle, 1);
    chk(!shiftStart && !xferDone, "R11 reset strobes", {shiftStart, xferDone}, 0);
    rstN = 1'b1;
    @(negedge clk);
    cfgEnable = 1'b1;
    @(negedge clk);
    // decode, cs, div, setup, hold, gap, switch, periods, change
    runXfer(0, 2, 0, 3, 2, 0, 5, 2, 0);
    runXfer(0, 2, 2, 0, 0, 1, 9, 3, 0);
    runXfer(1, 9, 1, 5, 4, 20, 7, 2, 0);
    runXfer(0, 0, 3, 1, 1, 3, 0, 3, 1);
    runXfer(0, 0, 0, 2, 3, 5, 4, 4, 0);
    runXfer(0, 3, 15, 2, 6, 40, 2, 1, 0);
    // R9: idle returns exactly when the gap expires (gap = max(40,32))
    n = 0;
    while (!idle && n < 200) begin @(negedge clk); n++; end
    chk(n == 40, "R9 idle after gap", n, 40);
    chk(q.size() == 0, "R4 scoreboard drained", q.size(), 0);
    monOn = 0;
    // R10: disabled request ignored
    cfgEnable = 1'b0;
    xferReq = 1'b1;
    n = 0;
    repeat (30) begin @(negedge clk); if (csN != 4'hF || sclk || !idle) n++; end
    chk(n == 0, "R10 request ignored while disabled", n, 0);
    cfgEnable = 1'b1;
    do @(negedge clk); while (!shiftStart);
    xferReq = 1'b0;
    @(negedge clk);
    cfgEnable = 1'b0;
    @(negedge clk);
    chk(csN == 4'hF, "R10 abort releases lines", csN, 4'hF);
    chk(sclk == 1'b0, "R10 abort stops clock", sclk, 0);
    chk(idle == 1'b1, "R10 abort idle", idle, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule